// File: doc/BRIEF.md
# Multiplexed Bus Address Demultiplexer and Strobe Decoder

This block sits on the system side of an 8-bit processor bus where the low address byte and the data byte share one set of lines. While the processor's address-valid strobe is high, the shared lines hold the low address byte, and the block passes it through. When the strobe falls, the block holds the last byte it captured, so that the shared lines can carry data without disturbing the address. The held byte is joined with the dedicated upper address lines to form a stable 16-bit address for the rest of the system.

The block also splits the processor's active-low read and write strobes by address space. It uses a space select input for this, where 0 means memory and 1 means I/O. The result is four separate active-low strobes. A direction output steers an external data transceiver toward the processor during reads. If read and write are both low at once, the block raises a fault flag and holds every decoded strobe inactive.

Top module: `muxbus_demux`

## Requirements
- R1: While reset is held and the address-valid strobe is low, the low byte of the address output is 0x00.
- R2: While the address-valid strobe is high, the low byte of the address output equals the shared lines in the same cycle.
- R3: After the address-valid strobe falls, the low byte of the address output keeps the value of the shared lines at the last clock edge where the strobe was high. Later changes on the shared lines have no effect on it until the strobe rises again.
- R4: The upper byte of the address output equals the upper address lines at all times, without a clock delay.
- R5: Memory read (active low) is 0 only when the space select is 0, read is 0 and write is 1.
- R6: Memory write (active low) is 0 only when the space select is 0, write is 0 and read is 1.
- R7: I/O read and I/O write (both active low) are 0 only when the space select is 1, the matching input strobe is 0 and the other strobe is 1.
- R8: When read and write are both 1, all four decoded strobes are 1, whatever the space select is.
- R9: When read and write are both 0, the fault flag is 1, all four decoded strobes are 1, and the direction output is 0. Otherwise the fault flag is 0.
- R10: The direction output is 1 (toward the processor) exactly when memory read or I/O read is asserted.
- R11: The decoded strobes and the direction output follow their inputs in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the low-byte holding register |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | High while the shared lines carry the low address byte |
| ad_bus | input | 8 | Shared address/data lines |
| addr_hi | input | 8 | Dedicated upper address lines |
| space_io | input | 1 | Space select: 0 memory, 1 I/O |
| rd_n | input | 1 | Processor read strobe, active low |
| wr_n | input | 1 | Processor write strobe, active low |
| addr | output | 16 | Demultiplexed address {upper, held low} |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| xcvr_to_cpu | output | 1 | Transceiver direction: 1 drives data toward the processor |
| bus_fault | output | 1 | Read and write both asserted |

## Verification
The assertions check the strobe behaviour on every clock edge:
- at most one decoded strobe is active,
- every active strobe matches its space and input strobe,
- the fault condition blocks every strobe,
- the direction output matches the read strobes,
- the upper byte passes straight through,
- the held low byte stays stable while the address-valid strobe stays low.

Other behaviours depend on the exact value of an earlier cycle, so only the bench scenarios show them. These are the captured value after the strobe falls, the value after reset, and the same-cycle response of each strobe to a full sweep of select and strobe inputs.

// File: rtl/muxbus_demux_pkg.sv
package muxbus_demux_pkg;

    typedef enum logic {
        SPACE_MEM = 1'b0,
        SPACE_IO  = 1'b1
    } space_e;

    localparam int unsigned NUM_SPACES = 2;

    typedef struct packed {
        logic mem_rd_n;
        logic mem_wr_n;
        logic io_rd_n;
        logic io_wr_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{mem_rd_n: 1'b1, mem_wr_n: 1'b1,
                                        io_rd_n: 1'b1, io_wr_n: 1'b1};

endpackage

// File: rtl/addr_lo_capture.sv
module addr_lo_capture #(
    parameter int unsigned LO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            addr_valid,
    input  logic [LO_W-1:0] ad_bus,
    output logic [LO_W-1:0] addr_lo
);

    typedef struct packed {
        logic [LO_W-1:0] held;
    } cap_state_t;

    cap_state_t state_d;
    cap_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (addr_valid) begin
            state_d.held = ad_bus;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Transparent while the strobe is high; the register holds once it falls.
    assign addr_lo = addr_valid ? ad_bus : state_q.held;

endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
    import muxbus_demux_pkg::*;
(
    input  logic    space_io,
    input  logic    rd_n,
    input  logic    wr_n,
    output strobe_t strobes,
    output logic    to_cpu,
    output logic    fault
);

    logic                  rd_req;
    logic                  wr_req;
    logic [NUM_SPACES-1:0] rd_act;
    logic [NUM_SPACES-1:0] wr_act;

    always_comb begin
        fault  = !rd_n && !wr_n;
        rd_req = !rd_n && !fault;
        wr_req = !wr_n && !fault;
    end

    for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
        localparam space_e SPACE = space_e'(s);
        assign rd_act[s] = rd_req && (space_e'(space_io) == SPACE);
        assign wr_act[s] = wr_req && (space_e'(space_io) == SPACE);
    end

    always_comb begin
        strobes          = STROBE_IDLE;
        strobes.mem_rd_n = !rd_act[SPACE_MEM];
        strobes.mem_wr_n = !wr_act[SPACE_MEM];
        strobes.io_rd_n  = !rd_act[SPACE_IO];
        strobes.io_wr_n  = !wr_act[SPACE_IO];
        to_cpu           = |rd_act;
    end

endmodule

// File: rtl/muxbus_demux.sv
module muxbus_demux
    import muxbus_demux_pkg::*;
#(
    parameter int unsigned LO_W = 8,
    parameter int unsigned HI_W = 8,
    localparam int unsigned ADDR_W = LO_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_valid,
    input  logic [LO_W-1:0]   ad_bus,
    input  logic [HI_W-1:0]   addr_hi,
    input  logic              space_io,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic [ADDR_W-1:0] addr,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              io_wr_n,
    output logic              xcvr_to_cpu,
    output logic              bus_fault
);

    logic [LO_W-1:0] addr_lo;
    strobe_t         strobes;

    addr_lo_capture #(.LO_W(LO_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_valid (addr_valid),
        .ad_bus     (ad_bus),
        .addr_lo    (addr_lo)
    );

    strobe_decode u_decode (
        .space_io (space_io),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .strobes  (strobes),
        .to_cpu   (xcvr_to_cpu),
        .fault    (bus_fault)
    );

    assign addr     = {addr_hi, addr_lo};
    assign mem_rd_n = strobes.mem_rd_n;
    assign mem_wr_n = strobes.mem_wr_n;
    assign io_rd_n  = strobes.io_rd_n;
    assign io_wr_n  = strobes.io_wr_n;

endmodule

// File: rtl/muxbus_demux_chk.sv
module muxbus_demux_chk #(
    parameter int unsigned LO_W = 8,
    parameter int unsigned HI_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 addr_valid,
    input logic [HI_W-1:0]      addr_hi,
    input logic                 space_io,
    input logic                 rd_n,
    input logic                 wr_n,
    input logic [LO_W+HI_W-1:0] addr,
    input logic                 mem_rd_n,
    input logic                 mem_wr_n,
    input logic                 io_rd_n,
    input logic                 io_wr_n,
    input logic                 xcvr_to_cpu,
    input logic                 bus_fault
);

    // R3
    held_lo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid && $past(!addr_valid)) |-> $stable(addr[LO_W-1:0]));

    // R4
    hi_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr[LO_W+HI_W-1:LO_W] == addr_hi);

    // R5
    mem_rd_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (!space_io && !rd_n && wr_n));

    // R6
    mem_wr_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (!space_io && !wr_n && rd_n));

    // R7
    io_strobe_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_rd_n || !io_wr_n) |-> space_io);

    // R7
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~mem_rd_n, ~mem_wr_n, ~io_rd_n, ~io_wr_n}));

    // R9
    fault_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !wr_n) |-> (bus_fault && mem_rd_n && mem_wr_n
                              && io_rd_n && io_wr_n && !xcvr_to_cpu));

    // R10
    dir_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_to_cpu == (!mem_rd_n || !io_rd_n));

endmodule

bind muxbus_demux muxbus_demux_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_valid  (addr_valid),
    .addr_hi     (addr_hi),
    .space_io    (space_io),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .addr        (addr),
    .mem_rd_n    (mem_rd_n),
    .mem_wr_n    (mem_wr_n),
    .io_rd_n     (io_rd_n),
    .io_wr_n     (io_wr_n),
    .xcvr_to_cpu (xcvr_to_cpu),
    .bus_fault   (bus_fault)
);

// File: tb/muxbus_demux_bench.sv
`timescale 1ns/1ps
module muxbus_demux_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        addr_valid;
    logic [7:0]  ad_bus;
    logic [7:0]  addr_hi;
    logic        space_io;
    logic        rd_n;
    logic        wr_n;
    logic [15:0] addr;
    logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, xcvr_to_cpu, bus_fault;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    muxbus_demux u_muxbus_demux (
        .clk (clk), .rst_n (rst_n), .addr_valid (addr_valid), .ad_bus (ad_bus),
        .addr_hi (addr_hi), .space_io (space_io), .rd_n (rd_n), .wr_n (wr_n),
        .addr (addr), .mem_rd_n (mem_rd_n), .mem_wr_n (mem_wr_n),
        .io_rd_n (io_rd_n), .io_wr_n (io_wr_n), .xcvr_to_cpu (xcvr_to_cpu),
        .bus_fault (bus_fault)
    );

    // {space_io, rd_n, wr_n, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, dir, fault}
    localparam logic [8:0] VEC [8] = '{
        9'b011_1111_00,
        9'b001_0111_10,
        9'b010_1011_00,
        9'b000_1111_01,
        9'b111_1111_00,
        9'b101_1101_10,
        9'b110_1110_00,
        9'b100_1111_01
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; addr_valid = 1'b0; ad_bus = 8'hA7; addr_hi = 8'h12;
        space_io = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset low byte", {16'h0, addr}, {16'h0, 16'h1200});
        @(negedge clk);
        rst_n = 1'b1;

        // Strobe sweep: same-cycle response, no clock edge between drive and sample.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            {space_io, rd_n, wr_n} = VEC[i][8:6];
            #1;
            check("R5 R6 R7 R8 R11 strobes", {28'h0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n},
                  {28'h0, VEC[i][5:2]});
            check("R10 direction", {31'h0, xcvr_to_cpu}, {31'h0, VEC[i][1]});
            check("R9 fault", {31'h0, bus_fault}, {31'h0, VEC[i][0]});
        end
        rd_n = 1'b1; wr_n = 1'b1;

        // R2: transparent while strobe high
        @(negedge clk);
        addr_valid = 1'b1; ad_bus = 8'h5A; addr_hi = 8'h3C;
        #1;
        check("R2 follow", {16'h0, addr}, {16'h0, 16'h3C5A});
        // R3: hold after fall, shared lines change to data
        @(negedge clk);
        addr_valid = 1'b0; ad_bus = 8'hC3;
        #1;
        check("R3 hold", {16'h0, addr}, {16'h0, 16'h3C5A});
        @(negedge clk);
        ad_bus = 8'h0F;
        @(negedge clk);
        #1;
        check("R3 hold later", {24'h0, addr[7:0]}, {24'h0, 8'h5A});
        // R4: upper byte passes straight through
        addr_hi = 8'hE1;
        #1;
        check("R4 upper", {24'h0, addr[15:8]}, {24'h0, 8'hE1});
        // Second address cycle with different value
        @(negedge clk);
        addr_valid = 1'b1; ad_bus = 8'h99;
        @(negedge clk);
        addr_valid = 1'b0; ad_bus = 8'h00;
        #1;
        check("R3 second capture", {16'h0, addr}, {16'h0, 16'hE199});
        // Read of I/O during data phase: direction and strobe with held address
        space_io = 1'b1; rd_n = 1'b0;
        #1;
        check("R7 io read data phase", {31'h0, io_rd_n}, 32'h0);
        check("R10 dir io read", {31'h0, xcvr_to_cpu}, 32'h1);
        // Write added on top -> fault blocks
        wr_n = 1'b0;
        #1;
        check("R9 fault blocks", {26'h0, io_rd_n, io_wr_n, mem_rd_n, mem_wr_n, xcvr_to_cpu, bus_fault},
              {26'h0, 6'b111101});
        rd_n = 1'b1; wr_n = 1'b1;
        #1;
        check("R8 idle", {28'h0, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, {28'h0, 4'hF});
        // Reset clears the held byte
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R1 reset clears held", {24'h0, addr[7:0]}, 32'h0);
        finish_run();
    end

endmodule